// File: doc/BRIEF.md
# Output Divider Alignment and Skew Controller

This block lines up the start of several clock output dividers. When an alignment event occurs, it puts every divider into reset together. It holds them there for a fixed minimum time. It then lets each divider go after its own programmed skew delay. All delays are counted on one fast timing clock, and one tick stands for 1/32 of the VCO period. Outputs whose skew code is zero leave reset on the same edge, so their falling edges line up. To get rising-edge alignment, software gives the faster output a code equal to half of its period in ticks, which is 180 degrees.

Three sources can start an alignment event:
- the end of power-on reset, but only while the hardware-select strap is high;
- any change of the configuration-select inputs;
- a rising edge on the software sync request.

All three inputs are asynchronous. The block synchronizes each of them, edge-detects it and merges the result into one request. A request that arrives while a sequence is running is absorbed into that sequence. When every divider has been released, a done flag rises and stays high until the next sequence starts.

Top module: `align_skew_ctrl`

## Requirements
- R1: While rst_ni is low, div_rst_o is all zeros and done_o is 0.
- R2: If hw_mode_i is high when reset is released, exactly one sequence starts within six cycles. If hw_mode_i is low, no sequence starts.
- R3: A change in the value of cfg_sel_i starts a sequence. div_rst_o becomes all ones on the fourth rising clock edge after the change, counting the first edge that samples the new value as edge one.
- R4: A rising edge of sw_sync_i starts a sequence. Holding sw_sync_i high, or taking it low, starts nothing more.
- R5: When a sequence starts, every bit of div_rst_o goes to 1 on the same edge and done_o goes to 0.
- R6: Output i is selected by field skew_code_i[i*SKEW_W +: SKEW_W], an unsigned count of 1/32-VCO-period ticks. Its div_rst_o[i] stays at 1 for exactly HOLD_CYC + code_i cycles. Once at 0, it stays at 0 until the next sequence starts.
- R7: skew_code_i is captured when a sequence starts. Changing it during the sequence does not affect that sequence's release times.
- R8: A request that arrives while a sequence is running is absorbed and starts nothing. This covers any request from the start edge through the cycle in which the last divider has just been released.
- R9: A cfg_sel_i change and a sw_sync_i rising edge seen in the same cycle start exactly one sequence.
- R10: done_o rises one cycle after the last div_rst_o bit falls. It stays at 1 with div_rst_o all zeros until the next sequence starts.
- R11: A request that first appears once done_o is already 1 starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast timing clock; one cycle is one skew tick |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_mode_i | input | 1 | Hardware-select strap; enables the power-on alignment |
| cfg_sel_i | input | SEL_W | Configuration-select inputs (asynchronous) |
| sw_sync_i | input | 1 | Software alignment request; acts on its rising edge |
| skew_code_i | input | NUM_OUT*SKEW_W | Per-output skew codes, output i at bits i*SKEW_W |
| div_rst_o | output | NUM_OUT | Per-divider reset; 1 holds the divider |
| done_o | output | 1 | All dividers released by the last sequence |

## Verification
Two events can collide with a sequence. The first is a configuration change that lands in the same cycle as a software edge. The bench drives both on one clock and expects a single start, counted from the rising edges of the reset outputs. The second is a request whose synchronized pulse reaches the sequencer exactly in the cycle when the last divider has just been released. The bench places a software edge at the last absorbed cycle and then one cycle later. It expects the first to be absorbed and the second to open a fresh sequence. The measured per-output reset widths are compared against HOLD_CYC plus each code taken from a table of code patterns.

// File: rtl/align_skew_pkg.sv
package align_skew_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/align_sync2.sv
module align_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/align_req_detect.sv
module align_req_detect #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_mode_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic             sw_sync_i,
  output logic             req_o
);
  localparam int BUS_W = SEL_W + 2;

  logic [BUS_W-1:0] raw, syn;
  logic             hw_s, sw_s;
  logic [SEL_W-1:0] sel_s, sel_q;
  logic             sw_q, req_q;
  logic [2:0]       arm_q;
  logic             por_d, chg_d, swe_d;

  assign raw = {hw_mode_i, sw_sync_i, cfg_sel_i};

  align_sync2 #(.W(BUS_W)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign hw_s  = syn[BUS_W-1];
  assign sw_s  = syn[SEL_W];
  assign sel_s = syn[SEL_W-1:0];

  // arm_q[2] marks that sel_q/sw_q hold real samples, so reset values never look like a change
  assign por_d = arm_q[1] & ~arm_q[2] & hw_s;
  assign chg_d = arm_q[2] & (sel_s != sel_q);
  assign swe_d = arm_q[2] & sw_s & ~sw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= '0;
      sel_q <= '0;
      sw_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      arm_q <= {arm_q[1:0], 1'b1};
      sel_q <= sel_s;
      sw_q  <= sw_s;
      req_q <= por_d | chg_d | swe_d;
    end
  end

  assign req_o = req_q;

  // R4
  quiet_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q[2] && $stable(sel_s) && !$rose(sw_s)) |=> !req_q);
endmodule

// File: rtl/align_seq.sv
module align_seq
  import align_skew_pkg::*;
#(
  parameter int HOLD_CYC = 8,
  parameter int CNT_W    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             all_rel_i,
  output logic             start_o,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign start_o = req_i && (state_q == SEQ_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (start_o) begin
      state_q <= SEQ_RUN;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (state_q == SEQ_RUN) begin
      if (all_rel_i) begin
        state_q <= SEQ_IDLE;
        done_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign run_o  = (state_q == SEQ_RUN);
  assign cnt_o  = cnt_q;
  assign done_o = done_q;

  // R8
  merge_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_RUN && req_i && !all_rel_i) |=>
      (state_q == SEQ_RUN && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/align_skew_release.sv
module align_skew_release #(
  parameter int HOLD_CYC = 8,
  parameter int SKEW_W   = 6,
  parameter int CNT_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [SKEW_W-1:0] code_i,
  output logic              div_rst_o
);
  logic [SKEW_W-1:0] code_q;
  logic              rel_q;
  logic [CNT_W-1:0]  target;

  assign target = CNT_W'(HOLD_CYC - 1) + CNT_W'(code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      rel_q  <= 1'b1;
    end else if (start_i) begin
      code_q <= code_i;
      rel_q  <= 1'b0;
    end else if (run_i && !rel_q && cnt_i == target) begin
      rel_q <= 1'b1;
    end
  end

  assign div_rst_o = ~rel_q;

  // R6
  stay_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_q && !start_i) |=> rel_q);
endmodule

// File: rtl/align_skew_ctrl.sv
module align_skew_ctrl #(
  parameter int NUM_OUT  = 4,
  parameter int SEL_W    = 2,
  parameter int SKEW_W   = 6,
  parameter int HOLD_CYC = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      hw_mode_i,
  input  logic [SEL_W-1:0]          cfg_sel_i,
  input  logic                      sw_sync_i,
  input  logic [NUM_OUT*SKEW_W-1:0] skew_code_i,
  output logic [NUM_OUT-1:0]        div_rst_o,
  output logic                      done_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + (1 << SKEW_W));

  logic             req, start, run, all_rel;
  logic [CNT_W-1:0] cnt;
  logic [NUM_OUT-1:0] div_rst_w;

  align_req_detect #(.SEL_W(SEL_W)) i_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_mode_i(hw_mode_i),
    .cfg_sel_i(cfg_sel_i),
    .sw_sync_i(sw_sync_i),
    .req_o    (req)
  );

  align_seq #(.HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .all_rel_i(all_rel),
    .start_o  (start),
    .run_o    (run),
    .cnt_o    (cnt),
    .done_o   (done_o)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    align_skew_release #(
      .HOLD_CYC(HOLD_CYC),
      .SKEW_W  (SKEW_W),
      .CNT_W   (CNT_W)
    ) i_rel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start),
      .run_i    (run),
      .cnt_i    (cnt),
      .code_i   (skew_code_i[g*SKEW_W +: SKEW_W]),
      .div_rst_o(div_rst_w[g])
    );
  end

  assign all_rel   = ~|div_rst_w;
  assign div_rst_o = div_rst_w;

  // R5
  start_all_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (div_rst_o == {NUM_OUT{1'b1}} && !done_o));

  // R6
  min_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt < CNT_W'(HOLD_CYC - 1)) |=> (div_rst_o == {NUM_OUT{1'b1}}));

  // R10
  done_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (div_rst_o == '0));
endmodule

// File: tb/test_align_skew_ctrl.sv
module test_align_skew_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_OUT    = 4;
  localparam int SEL_W      = 2;
  localparam int SKEW_W     = 6;
  localparam int HOLD_CYC   = 8;
  localparam int N_VEC      = 6;
  // each row: code0..code3, trigger (0 = cfg_sel change, 1 = sw edge)
  localparam int VEC_TAB [N_VEC][NUM_OUT+1] = '{
    '{0, 0, 0, 0, 0},
    '{0, 5, 10, 63, 1},
    '{63, 0, 1, 2, 0},
    '{7, 7, 7, 7, 1},
    '{1, 2, 3, 4, 0},
    '{32, 16, 8, 0, 1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic hw_mode;
  logic [SEL_W-1:0] cfg_sel;
  logic sw_sync;
  logic [NUM_OUT*SKEW_W-1:0] codes;
  logic [NUM_OUT-1:0] div_rst_o;
  logic done_o;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  bit prev_any = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  align_skew_ctrl #(
    .NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .SKEW_W(SKEW_W), .HOLD_CYC(HOLD_CYC)
  ) i_align_skew_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .hw_mode_i  (hw_mode),
    .cfg_sel_i  (cfg_sel),
    .sw_sync_i  (sw_sync),
    .skew_code_i(codes),
    .div_rst_o  (div_rst_o),
    .done_o     (done_o)
  );

  always @(negedge clk) begin
    if ((|div_rst_o) && !prev_any) starts++;
    prev_any = |div_rst_o;
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [NUM_OUT*SKEW_W-1:0] pack(input int c0, input int c1, input int c2, input int c3);
    logic [NUM_OUT*SKEW_W-1:0] v;
    v = {SKEW_W'(c3), SKEW_W'(c2), SKEW_W'(c1), SKEW_W'(c0)};
    return v;
  endfunction

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // follow one sequence from its start to done_o and check widths and done timing
  task automatic measure(input logic [NUM_OUT*SKEW_W-1:0] exp_codes, input string tag);
    int w [NUM_OUT];
    int g, n, last_hi, done_at;
    for (int i = 0; i < NUM_OUT; i++) w[i] = 0;
    g = 0;
    while (div_rst_o == '0 && g < 20) begin @(negedge clk); g++; end
    chk(div_rst_o == '1, {tag, " R5 all dividers held together"}, div_rst_o, 15);
    chk(done_o == 1'b0, {tag, " R5 done cleared at start"}, done_o, 0);
    n = 0; last_hi = -1; done_at = -1;
    while (done_at < 0 && n < 400) begin
      for (int i = 0; i < NUM_OUT; i++)
        if (div_rst_o[i]) begin w[i]++; last_hi = n; end
      if (done_o) done_at = n;
      @(negedge clk);
      n++;
    end
    for (int i = 0; i < NUM_OUT; i++)
      chk(w[i] == HOLD_CYC + int'(exp_codes[i*SKEW_W +: SKEW_W]),
          $sformatf("%s R6 width of output %0d", tag, i), w[i],
          HOLD_CYC + int'(exp_codes[i*SKEW_W +: SKEW_W]));
    chk(done_at == last_hi + 2, {tag, " R10 done one cycle after last release"}, done_at, last_hi + 2);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int s0;
    int n;
    rst_n = 1'b0; hw_mode = 1'b1; cfg_sel = '0; sw_sync = 1'b0;
    codes = pack(3, 0, 9, 1);
    wait_neg(3);
    // R1
    chk(div_rst_o == '0, "R1 div_rst in reset", div_rst_o, 0);
    chk(done_o == 1'b0, "R1 done in reset", done_o, 0);
    rst_n = 1'b1;
    // R2 power-on sequence in hardware mode
    n = 0;
    while (div_rst_o == '0 && n < 10) begin @(negedge clk); n++; end
    chk(n <= 6, "R2 power-on start latency", n, 6);
    measure(pack(3, 0, 9, 1), "R2");
    chk(starts == 1, "R2 exactly one power-on sequence", starts, 1);

    // table of code patterns
    for (int v = 0; v < N_VEC; v++) begin
      codes = pack(VEC_TAB[v][0], VEC_TAB[v][1], VEC_TAB[v][2], VEC_TAB[v][3]);
      @(negedge clk);
      if (VEC_TAB[v][NUM_OUT] == 1) begin
        sw_sync = 1'b1;
        measure(codes, $sformatf("vec%0d R4", v));
        sw_sync = 1'b0;
      end else begin
        cfg_sel = cfg_sel + 1'b1;
        measure(codes, $sformatf("vec%0d R3", v));
      end
      wait_neg(6);
    end

    // R3 exact latency of a select change
    codes = pack(1, 1, 1, 1);
    @(negedge clk);
    cfg_sel = cfg_sel + 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(div_rst_o == '0, "R3 not yet held after three edges", div_rst_o, 0);
    @(posedge clk);
    @(negedge clk);
    chk(div_rst_o == '1, "R3 held on fourth edge", div_rst_o, 15);
    wait_neg(20);

    // R4 level held and falling edge start nothing
    codes = pack(0, 2, 0, 2);
    s0 = starts;
    sw_sync = 1'b1;
    measure(codes, "R4");
    wait_neg(20);
    chk(starts == s0 + 1, "R4 held level no retrigger", starts, s0 + 1);
    sw_sync = 1'b0;
    wait_neg(10);
    chk(starts == s0 + 1, "R4 falling edge no trigger", starts, s0 + 1);

    // R7 and R8: code change and requests during a running sequence
    codes = pack(2, 4, 6, 8);
    s0 = starts;
    @(negedge clk);
    cfg_sel = cfg_sel + 1'b1;
    fork
      measure(pack(2, 4, 6, 8), "R7");
      begin
        wait_neg(7);
        codes = pack(20, 20, 20, 20);
        cfg_sel = cfg_sel + 1'b1;
        sw_sync = 1'b1;
        wait_neg(2);
        sw_sync = 1'b0;
        wait_neg(4);
        sw_sync = 1'b1;
        wait_neg(2);
        sw_sync = 1'b0;
      end
    join
    wait_neg(30);
    chk(starts == s0 + 1, "R8 mid-sequence requests absorbed", starts, s0 + 1);
    chk(done_o == 1'b1, "R10 done held after sequence", done_o, 1);

    // R9 simultaneous select change and software edge
    codes = pack(5, 0, 3, 1);
    s0 = starts;
    @(negedge clk);
    cfg_sel = cfg_sel + 1'b1;
    sw_sync = 1'b1;
    measure(codes, "R9");
    wait_neg(10);
    chk(starts == s0 + 1, "R9 one sequence from coincident causes", starts, s0 + 1);
    sw_sync = 1'b0;
    wait_neg(6);

    // R8 request landing in the completing cycle is absorbed
    codes = pack(0, 0, 0, 0);
    s0 = starts;
    @(negedge clk);
    cfg_sel = cfg_sel + 1'b1;
    wait_neg(HOLD_CYC + 1);
    sw_sync = 1'b1;
    wait_neg(3);
    sw_sync = 1'b0;
    wait_neg(40);
    chk(starts == s0 + 1, "R8 request in completing cycle absorbed", starts, s0 + 1);

    // R11 request one cycle later starts a new sequence
    s0 = starts;
    @(negedge clk);
    cfg_sel = cfg_sel + 1'b1;
    wait_neg(HOLD_CYC + 2);
    sw_sync = 1'b1;
    wait_neg(3);
    sw_sync = 1'b0;
    wait_neg(40);
    chk(starts == s0 + 2, "R11 request after done restarts", starts, s0 + 2);
    chk(done_o == 1'b1 && div_rst_o == '0, "R10 done and released at rest", done_o, 1);

    // R2 no power-on sequence in software mode
    rst_n = 1'b0;
    hw_mode = 1'b0;
    wait_neg(3);
    chk(div_rst_o == '0 && done_o == 1'b0, "R1 outputs in second reset", div_rst_o, 0);
    rst_n = 1'b1;
    s0 = starts;
    wait_neg(20);
    chk(starts == s0, "R2 no power-on sequence when strap low", starts, s0);
    chk(div_rst_o == '0, "R2 dividers free when strap low", div_rst_o, 0);

    finish_run();
  end
endmodule